// File: doc/BRIEF.md
# Colored Button Code Lock Controller

This controller releases a door lock only after a fixed entry sequence: the start button, followed by the red, blue, green and red color buttons, in that order. Each color button drives its own line. A separate strobe is high for the one cycle in which any colored press takes place. The controller sees each press as a one-cycle pulse. Debouncing and the lock actuator are handled outside the block.

Inside the block, a control FSM tracks how far the entry has progressed and tells a small press classifier which color it expects next. The classifier sends back a single-cycle verdict: either a clean hit, or a miss. A hit needs the strobe, the expected color line, and every other color line low. Any other strobed press is a miss. Because of this, a press that names several colors at once fails the entry. It never advances it.

The unlock output is a Moore output of the open state. It lasts exactly one cycle, after which the controller returns to idle on its own.

Top module: `code_lock_fsm`

## Requirements
- R1: While the synchronous, active-high `rst` is sampled high, the controller enters idle, and `unlock` is 0 from the following cycle.
- R2: In idle, the controller leaves idle only when `startBtn` is 1, and then moves to the armed state. In idle, the color lines and the strobe have no effect.
- R3: In the armed state and the three partial-entry states, a cycle with `colorStrobe`=0 keeps the state, whatever the color lines show.
- R4: The four strobed presses red, blue, green, red given after start raise `unlock` in the cycle after the fourth press. The color lines are coded {red,green,blue} = 100, 001, 010, 100.
- R5: A strobed press whose color pattern differs from the expected one returns the controller to idle. This includes a press with no color line set.
- R6: A strobed press with two or more color lines high returns the controller to idle, even when the expected color is among them.
- R7: `unlock` is 1 for exactly one cycle. The open state returns to idle on the next edge, whatever the inputs are.
- R8: `startBtn` has no effect in any state other than idle.
- R9: After a return to idle, a new complete sequence, starting again with `startBtn`, opens the lock again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| startBtn | input | 1 | Start button pulse |
| colorStrobe | input | 1 | High in any cycle that carries a colored press |
| redBtn | input | 1 | Red button line |
| greenBtn | input | 1 | Green button line |
| blueBtn | input | 1 | Blue button line |
| unlock | output | 1 | Door release, high for one cycle in the open state |

## Verification
In a single cycle, the start button can coincide with a colored press. The expected color can also arrive together with other colors. In both cases, advancing and failing compete for the same edge. The bench brings the controller to each progress stage and applies all 32 combinations of the five inputs there. A model kept in the bench predicts the next stage for each combination. The bench then drives the remaining correct presses and checks that `unlock` rises exactly when the predicted stage implies. This shows that start was ignored, or that a multi-color press threw the entry back to idle.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int NUM_COLORS = 3;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_FIRST  = 3'd2,
    ST_SECOND = 3'd3,
    ST_THIRD  = 3'd4,
    ST_OPEN   = 3'd5
  } lockState_t;

  // color vector order: {red, green, blue}
  localparam logic [NUM_COLORS-1:0] COL_RED   = 3'b100;
  localparam logic [NUM_COLORS-1:0] COL_GREEN = 3'b010;
  localparam logic [NUM_COLORS-1:0] COL_BLUE  = 3'b001;

  typedef struct packed {
    logic hit;
    logic miss;
  } verdict_t;
endpackage

// File: rtl/lock_press_check.sv
module lock_press_check
  import lock_pkg::*;
#(
  parameter int COLORS = NUM_COLORS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [COLORS-1:0] colorIn,
  input  logic [COLORS-1:0] expectVec,
  output verdict_t          verdict
);
  logic [COLORS-1:0] bitMatch;

  genvar i;
  generate
    for (i = 0; i < COLORS; i++) begin : g_match
      assign bitMatch[i] = (colorIn[i] == expectVec[i]);
    end
  endgenerate

  always_comb begin
    verdict.hit  = strobe && (&bitMatch) && (|expectVec);
    verdict.miss = strobe && !verdict.hit;
  end

  // R6
  multi_color_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(colorIn) > 1) |-> !verdict.hit);

  // R3
  no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> (!verdict.hit && !verdict.miss));

  expect_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(expectVec));
endmodule

// File: rtl/lock_control.sv
module lock_control
  import lock_pkg::*;
#(
  parameter int COLORS = NUM_COLORS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startBtn,
  input  verdict_t          verdict,
  output logic [COLORS-1:0] expectVec,
  output logic              unlock
);
  lockState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:   if (startBtn) stateD = ST_ARMED;
      ST_ARMED:  if (verdict.hit) stateD = ST_FIRST;  else if (verdict.miss) stateD = ST_IDLE;
      ST_FIRST:  if (verdict.hit) stateD = ST_SECOND; else if (verdict.miss) stateD = ST_IDLE;
      ST_SECOND: if (verdict.hit) stateD = ST_THIRD;  else if (verdict.miss) stateD = ST_IDLE;
      ST_THIRD:  if (verdict.hit) stateD = ST_OPEN;   else if (verdict.miss) stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    case (stateQ)
      ST_ARMED:  expectVec = COL_RED;
      ST_FIRST:  expectVec = COL_BLUE;
      ST_SECOND: expectVec = COL_GREEN;
      ST_THIRD:  expectVec = COL_RED;
      default:   expectVec = '0;
    endcase
  end

  assign unlock = (stateQ == ST_OPEN);

  // R7
  open_once_chk: assert property (@(posedge clk) disable iff (rst)
    unlock |=> !unlock);

  // R4
  open_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> $past(verdict.hit));

  // R5
  miss_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict.miss && stateQ != ST_IDLE) |=> (stateQ == ST_IDLE));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ != ST_IDLE && stateQ != ST_OPEN && !verdict.hit && !verdict.miss)
      |=> (stateQ == $past(stateQ)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE && !startBtn) |=> (stateQ == ST_IDLE));
endmodule

// File: rtl/code_lock_fsm.sv
module code_lock_fsm
  import lock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic startBtn,
  input  logic colorStrobe,
  input  logic redBtn,
  input  logic greenBtn,
  input  logic blueBtn,
  output logic unlock
);
  verdict_t                verdict;
  logic [NUM_COLORS-1:0]   expectVec;
  logic [NUM_COLORS-1:0]   colorVec;

  assign colorVec = {redBtn, greenBtn, blueBtn};

  lock_press_check #(.COLORS(NUM_COLORS)) i_check (
    .clk      (clk),
    .rst      (rst),
    .strobe   (colorStrobe),
    .colorIn  (colorVec),
    .expectVec(expectVec),
    .verdict  (verdict)
  );

  lock_control #(.COLORS(NUM_COLORS)) i_control (
    .clk      (clk),
    .rst      (rst),
    .startBtn (startBtn),
    .verdict  (verdict),
    .expectVec(expectVec),
    .unlock   (unlock)
  );
endmodule

// File: tb/test_code_lock_fsm.sv
module test_code_lock_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startBtn = 1'b0, colorStrobe = 1'b0;
  logic redBtn = 1'b0, greenBtn = 1'b0, blueBtn = 1'b0;
  logic unlock;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  code_lock_fsm i_code_lock_fsm (
    .clk(clk), .rst(rst), .startBtn(startBtn), .colorStrobe(colorStrobe),
    .redBtn(redBtn), .greenBtn(greenBtn), .blueBtn(blueBtn), .unlock(unlock)
  );

  // progress: 0 idle, 1 armed, 2..4 partial, 5 open
  function automatic logic [2:0] wantColor(int p);
    case (p)
      1: return 3'b100;
      2: return 3'b001;
      3: return 3'b010;
      4: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int nextProg(int p, logic s, logic a, logic [2:0] c);
    if (p == 0) return s ? 1 : 0;
    if (p == 5) return 0;
    if (!a) return p;
    if (c == wantColor(p)) return p + 1;
    return 0;
  endfunction

  task automatic check(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: unlock=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(logic s, logic a, logic [2:0] c);
    @(negedge clk);
    startBtn = s; colorStrobe = a;
    {redBtn, greenBtn, blueBtn} = c;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    startBtn = 0; colorStrobe = 0; {redBtn, greenBtn, blueBtn} = 3'b000;
    @(posedge clk); @(posedge clk); #1;
    check("R1", unlock, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reach(int p);
    if (p >= 1) step(1'b1, 1'b0, 3'b000);
    for (int k = 1; k < p; k++) step(1'b0, 1'b1, wantColor(k));
  endtask

  // finish an entry from progress q, checking unlock at each step
  task automatic complete(int q);
    int cur = q;
    if (cur == 5) begin
      step(1'b1, 1'b0, 3'b000);
      check("R7", unlock, 1'b0);
      cur = 0;
    end
    if (cur == 0) begin
      step(1'b1, 1'b0, 3'b000);
      check("R9", unlock, 1'b0);
      cur = 1;
    end
    while (cur < 5) begin
      step(1'b0, 1'b1, wantColor(cur));
      cur++;
      check("R4", unlock, cur == 5);
    end
    step(1'b0, 1'b0, 3'b000);
    check("R7", unlock, 1'b0);
  endtask

  initial begin
    doReset();
    check("R1", unlock, 1'b0);
    for (int p = 0; p <= 5; p++) begin
      for (int v = 0; v < 32; v++) begin
        logic s, a;
        logic [2:0] c;
        int q;
        string tag;
        s = v[4]; a = v[3]; c = v[2:0];
        doReset();
        reach(p);
        if (p == 5) check("R4", unlock, 1'b1);
        q = nextProg(p, s, a, c);
        if (p == 0) tag = "R2";
        else if (p == 5) tag = "R7";
        else if (!a && s) tag = "R8";
        else if (!a) tag = "R3";
        else if (c == wantColor(p)) tag = "R4";
        else if ($countones(c) > 1) tag = "R6";
        else tag = "R5";
        step(s, a, c);
        check(tag, unlock, q == 5);
        complete(q);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule